// File: doc/BRIEF.md
# Two-Level Address Translation Walker

The walker converts a 32-bit virtual address into a physical address by reading descriptors from a translation table in physical memory. It accepts one request at a time. A request carries a virtual address, a translate-enable flag and the table base in force. The walker then issues one or two word reads on a simple memory read port and reports the result with a one-cycle done strobe. The result is the physical address, the cacheable and bufferable attributes, the domain number, and a fault indication with its level.

The first read indexes a 4096-entry first-level table. That table is aligned to 16KB, and the entry is selected by the top 12 bits of the virtual address. The two low bits of the fetched word select the next step. A section descriptor maps a 1MB region directly. A coarse descriptor points to a 256-entry second-level table, aligned to 1KB, whose small-page descriptors map 4KB pages. Descriptor fetches always use physical addresses. When translation is disabled, the walker returns the virtual address unchanged and makes no read.

Top module: `xlat_walker`

## Requirements
- R1: After reset, reqReady is 1, doneValid is 0 and memRdValid is 0.
- R2: A request is taken in a cycle where reqValid and reqReady are both 1. reqReady is 0 from the next cycle until doneValid has been asserted. doneValid is high for exactly one cycle per request.
- R3: If xlatEnable is 0 when a request is taken, doneValid rises in the next cycle and no memory read is made. The result is physAddr equal to the virtual address, attrCache=0, attrBuffer=0, domainId=0 and fault=0.
- R4: The first-level read address is {tableBase[31:14], va[31:20], 2'b00}. Bits 13:0 of tableBase have no effect.
- R5: memRdValid stays high with a stable memRdAddr until a cycle in which memRdAck is 1. memRdData is taken in that cycle. doneValid follows one cycle after the ack of the last read.
- R6: A first-level descriptor d with d[1:0]=2'b10 is a section. It gives physAddr={d[31:20], va[19:0]}, attrCache=d[3], attrBuffer=d[2], domainId=d[8:5] and fault=0.
- R7: A first-level descriptor d with d[1:0]=2'b01 is a coarse pointer. It starts a second read at {d[31:10], va[19:12], 2'b00}. Bits 9:0 of d do not affect that address.
- R8: A second-level descriptor p with p[1:0]=2'b10 is a small page. It gives physAddr={p[31:12], va[11:0]}, attrCache=p[3] and attrBuffer=p[2]. domainId is taken from bits 8:5 of the first-level coarse descriptor, and fault is 0.
- R9: A first-level descriptor with d[1:0] equal to 2'b00 or 2'b11 ends the walk after one read. It gives fault=1, faultKind=0 (section level), physAddr=0, attrCache=0, attrBuffer=0 and domainId=0.
- R10: A second-level descriptor with p[1:0] other than 2'b10 gives fault=1 and faultKind=1 (page level). It also gives physAddr=0, attrCache=0, attrBuffer=0, and domainId from the first-level coarse descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to take a request |
| reqVaddr | input | 32 | Virtual address of the request |
| xlatEnable | input | 1 | 1 = translate, 0 = pass address through |
| tableBase | input | 32 | First-level table base (bits 31:14 used) |
| memRdValid | output | 1 | Descriptor read request |
| memRdAddr | output | 32 | Physical address of the descriptor word |
| memRdAck | input | 1 | Read data valid this cycle |
| memRdData | input | 32 | Descriptor word returned |
| doneValid | output | 1 | One-cycle result strobe |
| physAddr | output | 32 | Translated physical address |
| attrCache | output | 1 | Cacheable attribute |
| attrBuffer | output | 1 | Bufferable attribute |
| domainId | output | 4 | Domain number of the mapping |
| fault | output | 1 | Translation fault |
| faultKind | output | 1 | 0 = first-level fault, 1 = second-level fault |

## Verification
The checker assumes that the memory side raises memRdAck only while memRdValid is high, and only for one cycle per read. It also assumes that reqVaddr, xlatEnable and tableBase are valid whenever reqValid is high. The bench memory model enforces the first assumption: it answers only an outstanding read, after a latency of zero to three cycles, and it drops memRdAck in the cycle after each answer. The request driver raises reqValid only while reqReady is 1, holds it for the single accepting cycle, and drives every request field in that same cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int VA_W       = 32;
  localparam int L1_IDX_W   = 12;
  localparam int L2_IDX_W   = 8;
  localparam int PAGE_OFF_W = 12;
  localparam int DOM_W      = 4;
  localparam int WORD_SH    = 2;

  localparam int SECT_OFF_W = PAGE_OFF_W + L2_IDX_W;
  localparam int BASE_LO    = L1_IDX_W + WORD_SH;
  localparam int COARSE_LO  = L2_IDX_W + WORD_SH;
  localparam int BASE_W     = VA_W - BASE_LO;
  localparam int COARSE_W   = VA_W - COARSE_LO;

  localparam int BIT_BUF    = 2;
  localparam int BIT_CACHE  = 3;
  localparam int DOM_LO     = 5;

  localparam logic [1:0] KIND_COARSE = 2'b01;
  localparam logic [1:0] KIND_MAP    = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_DONE
  } walkState_e;

  typedef struct packed {
    logic capReq;
    logic ldBypass;
    logic ldSection;
    logic ldCoarse;
    logic ldPage;
    logic ldFault;
    logic faultIsPage;
    logic selL2;
  } walkCtl_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       xlatEnable,
  input  logic       memRdAck,
  input  logic [1:0] descKind,
  output logic       reqReady,
  output logic       memRdValid,
  output logic       doneValid,
  output walkCtl_t   ctl
);
  walkState_e state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext  = state;
    ctl        = '0;
    reqReady   = 1'b0;
    memRdValid = 1'b0;
    doneValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capReq = 1'b1;
          if (!xlatEnable) begin
            ctl.ldBypass = 1'b1;
            stateNext    = ST_DONE;
          end else begin
            stateNext = ST_L1;
          end
        end
      end
      ST_L1: begin
        memRdValid = 1'b1;
        if (memRdAck) begin
          if (descKind == KIND_MAP) begin
            ctl.ldSection = 1'b1;
            stateNext     = ST_DONE;
          end else if (descKind == KIND_COARSE) begin
            ctl.ldCoarse = 1'b1;
            stateNext    = ST_L2;
          end else begin
            ctl.ldFault = 1'b1;
            stateNext   = ST_DONE;
          end
        end
      end
      ST_L2: begin
        memRdValid = 1'b1;
        ctl.selL2  = 1'b1;
        if (memRdAck) begin
          if (descKind == KIND_MAP) begin
            ctl.ldPage = 1'b1;
          end else begin
            ctl.ldFault     = 1'b1;
            ctl.faultIsPage = 1'b1;
          end
          stateNext = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/xlat_dpath.sv
module xlat_dpath
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  walkCtl_t          ctl,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [VA_W-1:0]   tableBase,
  input  logic [VA_W-1:0]   memRdData,
  output logic [1:0]        descKind,
  output logic [VA_W-1:0]   memRdAddr,
  output logic [VA_W-1:0]   physAddr,
  output logic              attrCache,
  output logic              attrBuffer,
  output logic [DOM_W-1:0]  domainId,
  output logic              fault,
  output logic              faultKind
);
  logic [VA_W-1:0]     vaReg;
  logic [BASE_W-1:0]   baseHi;
  logic [COARSE_W-1:0] coarsePtr;
  logic [DOM_W-1:0]    l1Dom;

  logic [DOM_W-1:0]    rdDom;
  logic [VA_W-1:0]     l1Addr;
  logic [VA_W-1:0]     l2Addr;

  assign descKind = memRdData[1:0];
  assign rdDom    = memRdData[DOM_LO +: DOM_W];

  assign l1Addr = {baseHi, vaReg[VA_W-1:SECT_OFF_W], {WORD_SH{1'b0}}};
  assign l2Addr = {coarsePtr, vaReg[SECT_OFF_W-1:PAGE_OFF_W], {WORD_SH{1'b0}}};
  assign memRdAddr = ctl.selL2 ? l2Addr : l1Addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vaReg     <= '0;
      baseHi    <= '0;
      coarsePtr <= '0;
      l1Dom     <= '0;
    end else begin
      if (ctl.capReq) begin
        vaReg  <= reqVaddr;
        baseHi <= tableBase[VA_W-1:BASE_LO];
      end
      if (ctl.ldCoarse) begin
        coarsePtr <= memRdData[VA_W-1:COARSE_LO];
        l1Dom     <= rdDom;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      physAddr   <= '0;
      attrCache  <= 1'b0;
      attrBuffer <= 1'b0;
      domainId   <= '0;
      fault      <= 1'b0;
      faultKind  <= 1'b0;
    end else if (ctl.ldBypass) begin
      physAddr   <= reqVaddr;
      attrCache  <= 1'b0;
      attrBuffer <= 1'b0;
      domainId   <= '0;
      fault      <= 1'b0;
      faultKind  <= 1'b0;
    end else if (ctl.ldSection) begin
      physAddr   <= {memRdData[VA_W-1:SECT_OFF_W], vaReg[SECT_OFF_W-1:0]};
      attrCache  <= memRdData[BIT_CACHE];
      attrBuffer <= memRdData[BIT_BUF];
      domainId   <= rdDom;
      fault      <= 1'b0;
      faultKind  <= 1'b0;
    end else if (ctl.ldPage) begin
      physAddr   <= {memRdData[VA_W-1:PAGE_OFF_W], vaReg[PAGE_OFF_W-1:0]};
      attrCache  <= memRdData[BIT_CACHE];
      attrBuffer <= memRdData[BIT_BUF];
      domainId   <= l1Dom;
      fault      <= 1'b0;
      faultKind  <= 1'b0;
    end else if (ctl.ldFault) begin
      physAddr   <= '0;
      attrCache  <= 1'b0;
      attrBuffer <= 1'b0;
      domainId   <= ctl.faultIsPage ? l1Dom : '0;
      fault      <= 1'b1;
      faultKind  <= ctl.faultIsPage;
    end
  end
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic              xlatEnable,
  input  logic [VA_W-1:0]   tableBase,
  output logic              memRdValid,
  output logic [VA_W-1:0]   memRdAddr,
  input  logic              memRdAck,
  input  logic [VA_W-1:0]   memRdData,
  output logic              doneValid,
  output logic [VA_W-1:0]   physAddr,
  output logic              attrCache,
  output logic              attrBuffer,
  output logic [DOM_W-1:0]  domainId,
  output logic              fault,
  output logic              faultKind
);
  walkCtl_t   ctl;
  logic [1:0] descKind;

  xlat_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .xlatEnable (xlatEnable),
    .memRdAck   (memRdAck),
    .descKind   (descKind),
    .reqReady   (reqReady),
    .memRdValid (memRdValid),
    .doneValid  (doneValid),
    .ctl        (ctl)
  );

  xlat_dpath u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqVaddr   (reqVaddr),
    .tableBase  (tableBase),
    .memRdData  (memRdData),
    .descKind   (descKind),
    .memRdAddr  (memRdAddr),
    .physAddr   (physAddr),
    .attrCache  (attrCache),
    .attrBuffer (attrBuffer),
    .domainId   (domainId),
    .fault      (fault),
    .faultKind  (faultKind)
  );
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk
  import xlat_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [VA_W-1:0]   reqVaddr,
  input logic              xlatEnable,
  input logic              memRdValid,
  input logic [VA_W-1:0]   memRdAddr,
  input logic              memRdAck,
  input logic              doneValid,
  input logic [VA_W-1:0]   physAddr,
  input logic              attrCache,
  input logic              attrBuffer,
  input logic [DOM_W-1:0]  domainId,
  input logic              fault,
  input logic              faultKind
);
  // R2: result strobe lasts a single cycle
  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R2: no new request accepted while the result is presented
  p_busy_at_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !reqReady);

  // R5: read held steady until acknowledged, never while idle
  p_read_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memRdValid && !memRdAck) |=> (memRdValid && $stable(memRdAddr)));

  p_read_not_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    memRdValid |-> !reqReady);

  // R3: pass-through completes next cycle with the same address
  p_bypass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !xlatEnable) |=>
      (doneValid && !memRdValid && physAddr == $past(reqVaddr) && !fault));

  // R9 / R10: a fault carries no address or attributes
  p_fault_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && fault) |-> (physAddr == '0 && !attrCache && !attrBuffer));

  // R9: first-level fault reports domain zero
  p_sect_fault_dom_r9: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && fault && !faultKind) |-> (domainId == '0));
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqVaddr   (reqVaddr),
  .xlatEnable (xlatEnable),
  .memRdValid (memRdValid),
  .memRdAddr  (memRdAddr),
  .memRdAck   (memRdAck),
  .doneValid  (doneValid),
  .physAddr   (physAddr),
  .attrCache  (attrCache),
  .attrBuffer (attrBuffer),
  .domainId   (domainId),
  .fault      (fault),
  .faultKind  (faultKind)
);

// File: tb/xlat_walker_bench.sv
`timescale 1ns/1ps
module xlat_walker_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        xlatEnable = 1'b0;
  logic [31:0] tableBase = '0;
  logic        memRdValid;
  logic [31:0] memRdAddr;
  logic        memRdAck = 1'b0;
  logic [31:0] memRdData = '0;
  logic        doneValid;
  logic [31:0] physAddr;
  logic        attrCache, attrBuffer, fault, faultKind;
  logic [3:0]  domainId;

  always #2 clk = ~clk;

  xlat_walker u_xlat_walker (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqVaddr(reqVaddr), .xlatEnable(xlatEnable), .tableBase(tableBase),
    .memRdValid(memRdValid), .memRdAddr(memRdAddr), .memRdAck(memRdAck),
    .memRdData(memRdData), .doneValid(doneValid), .physAddr(physAddr),
    .attrCache(attrCache), .attrBuffer(attrBuffer), .domainId(domainId),
    .fault(fault), .faultKind(faultKind)
  );

  int checks = 0;
  int failures = 0;
  bit summaryDone = 0;

  logic [31:0] tbl [logic [31:0]];
  logic [31:0] expAddrQ [$];
  bit          doneDue = 0;
  int          waitCnt = 0;
  int          ackNum = 0;
  bit          sawDone;

  logic [31:0] expPa;
  logic        expC, expB, expF, expK;
  logic [3:0]  expDom;
  string       curTag;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return tbl.exists(a) ? tbl[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // behavioural reference of the walk
  task automatic refWalk(input logic [31:0] va, input logic [31:0] base, input bit en);
    logic [31:0] a1, d1, a2, d2;
    expAddrQ.delete();
    expC = 0; expB = 0; expF = 0; expK = 0; expDom = 0; expPa = 0;
    if (!en) begin
      expPa = va;
      return;
    end
    a1 = (base / 32'h4000) * 32'h4000 + (va / 32'h100000) * 4;
    expAddrQ.push_back(a1);
    d1 = rd(a1);
    if (d1 % 4 == 2) begin
      expPa  = (d1 / 32'h100000) * 32'h100000 + va % 32'h100000;
      expC   = (d1 / 8) % 2;
      expB   = (d1 / 4) % 2;
      expDom = (d1 / 32) % 16;
    end else if (d1 % 4 == 1) begin
      a2 = (d1 / 1024) * 1024 + ((va / 4096) % 256) * 4;
      expAddrQ.push_back(a2);
      d2 = rd(a2);
      expDom = (d1 / 32) % 16;
      if (d2 % 4 == 2) begin
        expPa = (d2 / 4096) * 4096 + va % 4096;
        expC  = (d2 / 8) % 2;
        expB  = (d2 / 4) % 2;
      end else begin
        expF = 1; expK = 1;
      end
    end else begin
      expF = 1; expK = 0;
    end
  endtask

  // one clock: advance to the next falling edge, then compare and drive memory
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    check(doneValid == doneDue, "R5", "done timing", {31'b0, doneValid}, {31'b0, doneDue});
    if (doneValid) begin
      sawDone = 1;
      check(!reqReady, "R2", "ready at done", {31'b0, reqReady}, 32'h0);
      check(physAddr == expPa, curTag, "physAddr", physAddr, expPa);
      check(attrCache == expC, curTag, "attrCache", {31'b0, attrCache}, {31'b0, expC});
      check(attrBuffer == expB, curTag, "attrBuffer", {31'b0, attrBuffer}, {31'b0, expB});
      check(domainId == expDom, curTag, "domainId", {28'b0, domainId}, {28'b0, expDom});
      check(fault == expF, curTag, "fault", {31'b0, fault}, {31'b0, expF});
      check(faultKind == expK, curTag, "faultKind", {31'b0, faultKind}, {31'b0, expK});
    end
    doneDue = 0;
    if (memRdAck) begin
      memRdAck = 0;
    end else if (memRdValid) begin
      if (expAddrQ.size() == 0) begin
        check(0, "R3", "unexpected read", memRdAddr, 32'h0);
      end else if (waitCnt > 0) begin
        waitCnt--;
      end else begin
        check(memRdAddr == expAddrQ[0], (expAddrQ.size() == 2) ? "R4" : "R7",
              "read address", memRdAddr, expAddrQ[0]);
        void'(expAddrQ.pop_front());
        memRdData = rd(memRdAddr);
        memRdAck  = 1;
        if (expAddrQ.size() == 0) doneDue = 1;
        ackNum++;
        waitCnt = (ackNum * 5 + 1) % 4;
      end
    end
  endtask

  task automatic request(input logic [31:0] va, input logic [31:0] base,
                         input bit en, input string tag);
    curTag = tag;
    check(reqReady == 1, "R2", "ready before request", {31'b0, reqReady}, 32'h1);
    refWalk(va, base, en);
    reqValid = 1; reqVaddr = va; tableBase = base; xlatEnable = en;
    if (!en) doneDue = 1;
    sawDone = 0;
    cycle();
    reqValid = 0; reqVaddr = 32'hDEAD_BEEF; tableBase = 32'hFFFF_FFFF; xlatEnable = 0;
    for (int i = 0; i < 40 && !sawDone; i++) begin
      if (!sawDone) check(reqReady == 0, "R2", "ready while busy", {31'b0, reqReady}, 32'h0);
      cycle();
    end
    check(sawDone, tag, "completion", {31'b0, sawDone}, 32'h1);
    cycle();
    check(reqReady == 1, "R2", "ready after done", {31'b0, reqReady}, 32'h1);
  endtask

  initial begin
    // first level at 0x4000
    tbl[32'h0000_448C] = 32'hABC0_0000 | (5 << 5) | 32'hC | 32'h2;  // section, C B, dom 5
    tbl[32'h0000_5FFC] = 32'h0010_0000 | (15 << 5) | 32'h4 | 32'h2; // section, B, dom 15
    tbl[32'h0000_4800] = 32'h0001_0400 | (9 << 5) | 32'h1;          // coarse, dom 9
    tbl[32'h0000_4C04] = 32'h1230_0003;                             // kind 11
    tbl[32'h0001_0514] = 32'h5555_500A;                             // page, C
    tbl[32'h0001_07FC] = 32'hFEDC_B00E;                             // page, C B

    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady == 1, "R1", "reqReady", {31'b0, reqReady}, 32'h1);
    check(doneValid == 0, "R1", "doneValid", {31'b0, doneValid}, 32'h0);
    check(memRdValid == 0, "R1", "memRdValid", {31'b0, memRdValid}, 32'h0);
    rstN = 1;
    @(negedge clk);

    request(32'h89AB_CDEF, 32'h0000_4000, 0, "R3");
    request(32'h1234_5678, 32'h0000_4000, 1, "R6");
    request(32'h1234_5678, 32'h0000_7ABC, 1, "R4");
    request(32'h7FF0_0010, 32'h0000_4000, 1, "R6");
    request(32'h2004_5ABC, 32'h0000_4000, 1, "R8");
    request(32'h200F_F001, 32'h0000_4000, 1, "R7");
    request(32'h2004_6000, 32'h0000_4000, 1, "R10");
    request(32'h3001_2345, 32'h0000_4000, 1, "R9");
    request(32'h3011_2345, 32'h0000_4000, 1, "R9");
    request(32'h0000_0000, 32'h0000_4000, 0, "R3");
    request(32'h2004_5FFF, 32'h0000_4000, 1, "R8");

    if (!summaryDone) begin
      summaryDone = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!summaryDone) begin
      summaryDone = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule